// File: doc/BRIEF.md
# Nibble Receive Framer with Pad Stripping

This block sits on the receive side of a 10/100 Ethernet MAC. It takes a 4-bit nibble stream and a data-valid strobe from the PHY. It drops the preamble, locks onto the start-of-frame delimiter and packs the following nibbles into bytes. Those bytes go out on the write port of a receive FIFO, with markers for the first byte, the last byte and discard.

The block reads the big-endian length/type field at byte offsets 12 and 13. When pad stripping is enabled and that field holds a length below 46, only the header and the stated number of data bytes are written. The pad and the four FCS bytes are dropped. A frame shorter than 64 received bytes, or one that sees a collision before its 64th byte, ends with a discard marker so the FIFO can roll back its write pointer. Setting the runt-keep option suppresses this.

A one-byte holding stage sits in front of the write port. It lets the end and discard markers travel with the last written byte, which in general is known only once data-valid drops.

Top module: `nib_rx_framer`

## Requirements
- R1: Preamble nibbles and any nibbles before the delimiter are never written. Framing starts only after a nibble 0x5 is directly followed by a nibble 0xD while data-valid is high. A burst that drops data-valid without that pair writes nothing.
- R2: Each byte is assembled from two nibbles, the first received nibble forming bits 3:0 and the second bits 7:4. Written bytes keep their received values and order.
- R3: Out of reset no write is signalled. The first written byte of a frame carries the start marker. The last written byte carries the end marker and is written only after data-valid has dropped.
- R4: With stripping enabled and the length field (byte 12 high, byte 13 low) below 46, exactly 14 plus that many bytes are written, or all received bytes if fewer arrived.
- R5: A length field from 46 to 1500 causes every received byte, FCS included, to be written, whatever the real frame length.
- R6: A length/type value above 1500 is a type, and no stripping is applied.
- R7: With stripping disabled every received byte is written.
- R8: A frame with fewer than 64 received bytes after the delimiter ends with the discard marker on its last written byte. A frame of exactly 64 bytes does not.
- R9: A collision seen before 64 bytes have been received marks the frame for discard. A collision after that point has no effect.
- R10: With runt keep set when the delimiter is found, the discard marker is never raised for that frame.
- R11: A trailing odd nibble is ignored. It neither forms a byte nor counts toward the frame length.
- R12: A frame that ends right after the delimiter writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_dv_i | input | 1 | Nibble data valid from the PHY |
| rx_nib_i | input | 4 | Receive nibble |
| col_i | input | 1 | Collision indication |
| pad_strip_en_i | input | 1 | Enable pad and FCS removal for short length frames |
| runt_keep_i | input | 1 | Keep short or collided frames instead of discarding them |
| wr_en_o | output | 1 | FIFO write strobe |
| wr_data_o | output | 8 | FIFO write byte |
| wr_sof_o | output | 1 | Marks the first written byte of a frame |
| wr_eof_o | output | 1 | Marks the last written byte of a frame |
| wr_discard_o | output | 1 | With the end marker, asks the FIFO to drop the frame |

## Verification
The checker assumes that pad_strip_en_i and runt_keep_i are held stable for the whole of each frame. It also assumes that data-valid stays low for at least two cycles between frames, so an end marker is never seen while the next burst is already running. The bench changes the configuration only while data-valid is low and leaves eight idle cycles after every frame. It raises the collision input only while a frame is being received.

// File: rtl/nrf_pkg.sv
package nrf_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam logic [NIB_W-1:0] PRE_NIB = 4'h5;
  localparam logic [NIB_W-1:0] SFD_NIB = 4'hD;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_HUNT  = 2'd1,
    HS_FRAME = 2'd2
  } hunt_st_e;
endpackage

// File: rtl/nrf_nib_pack.sv
module nrf_nib_pack
  import nrf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dv_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic              sof_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              end_o,
  output logic              in_frame_o
);
  hunt_st_e         st_q;
  logic [NIB_W-1:0] prev_q, low_q;
  logic             prev_vld_q, phase_q;

  assign in_frame_o = (st_q == HS_FRAME);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= HS_IDLE;
      prev_q     <= '0;
      low_q      <= '0;
      prev_vld_q <= 1'b0;
      phase_q    <= 1'b0;
      sof_o      <= 1'b0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      end_o      <= 1'b0;
    end else begin
      sof_o      <= 1'b0;
      byte_vld_o <= 1'b0;
      end_o      <= 1'b0;
      case (st_q)
        HS_IDLE, HS_HUNT: begin
          if (dv_i) begin
            prev_q     <= nib_i;
            prev_vld_q <= 1'b1;
            st_q       <= HS_HUNT;
            if (prev_vld_q && prev_q == PRE_NIB && nib_i == SFD_NIB) begin
              st_q    <= HS_FRAME;
              sof_o   <= 1'b1;
              phase_q <= 1'b0;
            end
          end else begin
            st_q       <= HS_IDLE;
            prev_vld_q <= 1'b0;
          end
        end
        HS_FRAME: begin
          if (dv_i) begin
            if (!phase_q) begin
              low_q <= nib_i;
            end else begin
              byte_vld_o <= 1'b1;
              byte_o     <= {nib_i, low_q};
            end
            phase_q <= ~phase_q;
          end else begin
            // odd trailing nibble in low_q is simply dropped
            end_o      <= 1'b1;
            st_q       <= HS_IDLE;
            prev_vld_q <= 1'b0;
          end
        end
        default: st_q <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nrf_len_ctl.sv
module nrf_len_ctl
  import nrf_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int LEN_OFS   = 12,
  parameter int PAD_LIMIT = 46,
  parameter int MAX_LEN   = 1500,
  parameter int MIN_FRAME = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              in_frame_i,
  input  logic              col_i,
  input  logic              pad_en_i,
  input  logic              runt_keep_i,
  output logic              keep_o,
  output logic              discard_o
);
  localparam int HDR   = LEN_OFS + 2;
  localparam int LIM_W = CNT_W + 17;
  localparam logic [CNT_W-1:0] IDX_HI  = CNT_W'(LEN_OFS);
  localparam logic [CNT_W-1:0] IDX_LO  = CNT_W'(LEN_OFS + 1);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_FRAME);
  localparam logic [15:0]      PAD_LIM = 16'(PAD_LIMIT);
  localparam logic [15:0]      LEN_MAX = 16'(MAX_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      len_q;
  logic             len_ok_q, pad_q, rk_q, col_q;
  logic             cnt_sat, strip_act, runt;
  logic [LIM_W-1:0] cnt_x, lim_x;

  assign cnt_sat = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      len_q    <= '0;
      len_ok_q <= 1'b0;
      pad_q    <= 1'b0;
      rk_q     <= 1'b0;
      col_q    <= 1'b0;
    end else if (sof_i) begin
      cnt_q    <= '0;
      len_ok_q <= 1'b0;
      pad_q    <= pad_en_i;
      rk_q     <= runt_keep_i;
      col_q    <= 1'b0;
    end else begin
      if (byte_vld_i && !cnt_sat) cnt_q <= cnt_q + 1'b1;
      if (byte_vld_i && cnt_q == IDX_HI) len_q[15:8] <= byte_i;
      if (byte_vld_i && cnt_q == IDX_LO) begin
        len_q[7:0] <= byte_i;
        len_ok_q   <= 1'b1;
      end
      if (in_frame_i && col_i && cnt_q < MIN_CNT) col_q <= 1'b1;
    end
  end

  // type values above MAX_LEN never strip
  assign strip_act = pad_q && len_ok_q && (len_q < PAD_LIM) && (len_q <= LEN_MAX);
  assign cnt_x     = LIM_W'(cnt_q);
  assign lim_x     = LIM_W'(HDR) + LIM_W'(len_q);
  assign keep_o    = !strip_act || (cnt_x < lim_x);
  assign runt      = cnt_q < MIN_CNT;
  assign discard_o = !rk_q && (runt || col_q);
endmodule

// File: rtl/nrf_hold_out.sv
module nrf_hold_out
  import nrf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              byte_vld_i,
  input  logic              keep_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              end_i,
  input  logic              discard_i,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_sof_o,
  output logic              wr_eof_o,
  output logic              wr_discard_o
);
  logic [BYTE_W-1:0] hold_q;
  logic              hold_vld_q, first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q       <= '0;
      hold_vld_q   <= 1'b0;
      first_q      <= 1'b0;
      wr_en_o      <= 1'b0;
      wr_data_o    <= '0;
      wr_sof_o     <= 1'b0;
      wr_eof_o     <= 1'b0;
      wr_discard_o <= 1'b0;
    end else begin
      wr_en_o      <= 1'b0;
      wr_sof_o     <= 1'b0;
      wr_eof_o     <= 1'b0;
      wr_discard_o <= 1'b0;
      if (sof_i) begin
        first_q    <= 1'b1;
        hold_vld_q <= 1'b0;
      end else if (byte_vld_i && keep_i) begin
        if (hold_vld_q) begin
          wr_en_o   <= 1'b1;
          wr_data_o <= hold_q;
          wr_sof_o  <= first_q;
          first_q   <= 1'b0;
        end
        hold_q     <= byte_i;
        hold_vld_q <= 1'b1;
      end else if (end_i) begin
        if (hold_vld_q) begin
          wr_en_o      <= 1'b1;
          wr_data_o    <= hold_q;
          wr_sof_o     <= first_q;
          wr_eof_o     <= 1'b1;
          wr_discard_o <= discard_i;
        end
        first_q    <= 1'b0;
        hold_vld_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nib_rx_framer.sv
module nib_rx_framer
  import nrf_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int LEN_OFS   = 12,
  parameter int PAD_LIMIT = 46,
  parameter int MAX_LEN   = 1500,
  parameter int MIN_FRAME = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_dv_i,
  input  logic [3:0] rx_nib_i,
  input  logic       col_i,
  input  logic       pad_strip_en_i,
  input  logic       runt_keep_i,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       wr_sof_o,
  output logic       wr_eof_o,
  output logic       wr_discard_o
);
  logic              sof, byte_vld, end_p, in_frame, keep, discard;
  logic [BYTE_W-1:0] byte_d;

  nrf_nib_pack u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dv_i       (rx_dv_i),
    .nib_i      (rx_nib_i),
    .sof_o      (sof),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_d),
    .end_o      (end_p),
    .in_frame_o (in_frame)
  );

  nrf_len_ctl #(
    .CNT_W     (CNT_W),
    .LEN_OFS   (LEN_OFS),
    .PAD_LIMIT (PAD_LIMIT),
    .MAX_LEN   (MAX_LEN),
    .MIN_FRAME (MIN_FRAME)
  ) u_len (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sof_i       (sof),
    .byte_vld_i  (byte_vld),
    .byte_i      (byte_d),
    .in_frame_i  (in_frame),
    .col_i       (col_i),
    .pad_en_i    (pad_strip_en_i),
    .runt_keep_i (runt_keep_i),
    .keep_o      (keep),
    .discard_o   (discard)
  );

  nrf_hold_out u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sof_i        (sof),
    .byte_vld_i   (byte_vld),
    .keep_i       (keep),
    .byte_i       (byte_d),
    .end_i        (end_p),
    .discard_i    (discard),
    .wr_en_o      (wr_en_o),
    .wr_data_o    (wr_data_o),
    .wr_sof_o     (wr_sof_o),
    .wr_eof_o     (wr_eof_o),
    .wr_discard_o (wr_discard_o)
  );
endmodule

// File: rtl/nrf_chk.sv
module nrf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_dv_i,
  input logic runt_keep_i,
  input logic wr_en_o,
  input logic wr_sof_o,
  input logic wr_eof_o,
  input logic wr_discard_o
);
  logic open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b0;
    else if (wr_en_o && wr_eof_o) open_q <= 1'b0;
    else if (wr_en_o && wr_sof_o) open_q <= 1'b1;
  end

  AST_SOF_HAS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sof_o |-> wr_en_o); // R3
  AST_EOF_HAS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_eof_o |-> wr_en_o); // R3
  AST_NO_NESTED_SOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sof_o |-> !open_q); // R3
  AST_WR_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !wr_sof_o) |-> open_q); // R3
  AST_EOF_DV_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_eof_o |-> !rx_dv_i); // R3
  AST_DISC_HAS_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_discard_o |-> wr_eof_o); // R8
  AST_KEEP_NO_DISC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_discard_o |-> !runt_keep_i); // R10
endmodule

bind nib_rx_framer nrf_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_dv_i      (rx_dv_i),
  .runt_keep_i  (runt_keep_i),
  .wr_en_o      (wr_en_o),
  .wr_sof_o     (wr_sof_o),
  .wr_eof_o     (wr_eof_o),
  .wr_discard_o (wr_discard_o)
);

// File: tb/nib_rx_framer_tb.sv
`timescale 1ns/1ps
module nib_rx_framer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_dv = 1'b0;
  logic [3:0] rx_nib = '0;
  logic       col = 1'b0;
  logic       pad_en = 1'b0;
  logic       rkeep = 1'b0;
  logic       wr_en, wr_sof, wr_eof, wr_disc;
  logic [7:0] wr_data;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R3";

  typedef struct packed {
    logic [7:0] d;
    logic       s;
    logic       e;
    logic       x;
  } item_t;
  item_t exp_q[$];

  always #2 clk = ~clk;

  nib_rx_framer u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .rx_dv_i        (rx_dv),
    .rx_nib_i       (rx_nib),
    .col_i          (col),
    .pad_strip_en_i (pad_en),
    .runt_keep_i    (rkeep),
    .wr_en_o        (wr_en),
    .wr_data_o      (wr_data),
    .wr_sof_o       (wr_sof),
    .wr_eof_o       (wr_eof),
    .wr_discard_o   (wr_disc)
  );

  // monitor: pops expected items as writes appear
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected write data=%02h sof=%0b eof=%0b disc=%0b expected none",
                 cur_tag, wr_data, wr_sof, wr_eof, wr_disc);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if ({wr_data, wr_sof, wr_eof, wr_disc} !== {e.d, e.s, e.e, e.x}) begin
          errors++;
          $display("FAIL %s data/sof/eof/disc actual=%02h/%0b/%0b/%0b expected=%02h/%0b/%0b/%0b",
                   cur_tag, wr_data, wr_sof, wr_eof, wr_disc, e.d, e.s, e.e, e.x);
        end
      end
    end
  end

  task automatic drive_nib(input logic [3:0] n, input logic c);
    @(negedge clk);
    rx_dv  = 1'b1;
    rx_nib = n;
    col    = c;
  endtask

  task automatic finish_frame(input string tag);
    @(negedge clk);
    rx_dv = 1'b0;
    col   = 1'b0;
    repeat (8) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s pending items actual=%0d expected=0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  // n bytes after the delimiter; col_at = byte index with collision, -1 none
  task automatic send_frame(input string tag, input int n, input int seed, input int len_field,
                            input bit pad, input bit rk, input int col_at, input bit dribble);
    logic [7:0] fb[256];
    int  keep_n;
    bit  strip, disc;
    cur_tag = tag;
    pad_en  = pad;
    rkeep   = rk;
    for (int i = 0; i < n; i++) fb[i] = 8'(i * 13 + seed);
    if (n >= 14) begin
      fb[12] = 8'(len_field >> 8);
      fb[13] = 8'(len_field);
    end
    strip  = pad && (n >= 14) && (len_field < 46);
    keep_n = n;
    if (strip && (14 + len_field) < n) keep_n = 14 + len_field;
    disc   = !rk && ((n < 64) || (col_at >= 0 && col_at < 64));
    for (int i = 0; i < keep_n; i++) begin
      item_t it;
      it.d = fb[i];
      it.s = (i == 0);
      it.e = (i == keep_n - 1);
      it.x = (i == keep_n - 1) && disc;
      exp_q.push_back(it);
    end
    // leading noise and preamble, then delimiter (R1)
    drive_nib(4'hA, 1'b0);
    drive_nib(4'h0, 1'b0);
    for (int i = 0; i < 13; i++) drive_nib(4'h5, 1'b0);
    drive_nib(4'hD, 1'b0);
    for (int i = 0; i < n; i++) begin
      drive_nib(fb[i][3:0], i == col_at);
      drive_nib(fb[i][7:4], i == col_at);
    end
    if (dribble) drive_nib(4'h3, 1'b0);
    finish_frame(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3: reset state
    checks++;
    if ({wr_en, wr_sof, wr_eof, wr_disc} !== 4'b0) begin
      errors++;
      $display("FAIL R3 reset outputs actual=%b expected=0000", {wr_en, wr_sof, wr_eof, wr_disc});
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: preamble without delimiter, then a lone D with no 5 before it
    cur_tag = "R1";
    for (int i = 0; i < 20; i++) drive_nib(4'h5, 1'b0);
    finish_frame("R1");
    drive_nib(4'h7, 1'b0);
    drive_nib(4'hD, 1'b0);
    for (int i = 0; i < 10; i++) drive_nib(4'h1, 1'b0);
    finish_frame("R1");

    send_frame("R2 R7 plain", 70, 3, 64, 1'b0, 1'b0, -1, 1'b0);
    send_frame("R4 strip len20", 64, 5, 20, 1'b1, 1'b0, -1, 1'b0);
    send_frame("R4 strip len0", 64, 9, 0, 1'b1, 1'b0, -1, 1'b0);
    send_frame("R4 strip len45", 64, 11, 45, 1'b1, 1'b0, -1, 1'b0);
    send_frame("R4 R8 strip runt", 30, 17, 5, 1'b1, 1'b0, -1, 1'b0);
    send_frame("R5 len46 long", 100, 21, 46, 1'b1, 1'b0, -1, 1'b0);
    send_frame("R5 len1500", 66, 23, 1500, 1'b1, 1'b0, -1, 1'b0);
    send_frame("R6 type", 80, 27, 16'h0800, 1'b1, 1'b0, -1, 1'b0);
    send_frame("R7 nostrip", 64, 31, 20, 1'b0, 1'b0, -1, 1'b0);
    send_frame("R8 runt40", 40, 33, 200, 1'b0, 1'b0, -1, 1'b0);
    send_frame("R8 runt63", 63, 35, 200, 1'b0, 1'b0, -1, 1'b0);
    send_frame("R8 exact64", 64, 37, 200, 1'b0, 1'b0, -1, 1'b0);
    send_frame("R9 early col", 90, 41, 300, 1'b0, 1'b0, 10, 1'b0);
    send_frame("R9 late col", 90, 43, 300, 1'b0, 1'b0, 80, 1'b0);
    send_frame("R10 keep runt", 40, 47, 200, 1'b0, 1'b1, -1, 1'b0);
    send_frame("R10 keep col", 90, 49, 300, 1'b0, 1'b1, 10, 1'b0);
    send_frame("R11 dribble", 70, 51, 300, 1'b0, 1'b0, -1, 1'b1);
    send_frame("R11 dribble runt", 63, 53, 300, 1'b0, 1'b0, -1, 1'b1);
    send_frame("R12 empty", 0, 55, 0, 1'b0, 1'b0, -1, 1'b0);
    send_frame("R12 empty dribble", 0, 57, 0, 1'b1, 1'b0, -1, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule